// File: doc/BRIEF.md
# Per-Task Wait Retry Flags

In a pipeline that interleaves four hardware tasks, a wait-type instruction whose condition is not yet met does not freeze the pipeline. Instead it re-issues itself by leaving that task's instruction pointer where it is. An instruction whose operand address carries a pre- or post-increment (or decrement) would apply that modify again on every pass. The final access would then land far from the intended address.

This block keeps one retry flag per task, next to that task's instruction pointer. The execute stage reports a re-issue for a task, and the flag is set. The flag clears when the task's pointer moves, either by a normal advance or by a branch load. Until then, the flag tells the pointer-modify stage to leave the address registers of that task alone. The flags are registered, and the vector of flags is the block's output.

Top module: `task_retry_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `suppress` is 0 after that edge.
- R2: In multitask mode (`multi_mode`=1), a `retry_valid` pulse with `retry_task`=t (binary task index 0..3) sets bit t of `suppress` after the edge, unless a clear for task t arrives in the same cycle.
- R3: An `adv_valid` pulse with `adv_task`=t clears bit t of `suppress` after the edge.
- R4: A `jump_valid` pulse with `jump_task`=t (branch loads a new pointer) clears bit t of `suppress` after the edge.
- R5: When a retry and a clear (advance or jump) name the same task in one cycle, the clear wins and the bit is 0 afterwards.
- R6: In single-task mode (`multi_mode`=0) no bit is ever set, and every bit is 0 after any edge at which `multi_mode` is 0.
- R7: Each task's bit changes only through events that name that task. With no such event it holds its value.
- R8: `suppress` is a registered output. An event changes it only after the next rising edge and never within the cycle in which the event is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| multi_mode | input | 1 | 1 = interleaved multitask mode, 0 = single-task mode |
| retry_valid | input | 1 | An instruction failed to complete and re-issues itself |
| retry_task | input | 2 | Task index of the re-issued instruction |
| adv_valid | input | 1 | A task's pointer incremented on completion |
| adv_task | input | 2 | Task index of the advance |
| jump_valid | input | 1 | A branch loaded a new pointer |
| jump_task | input | 2 | Task index of the branch |
| suppress | output | 4 | Per-task inhibit of pre/post address modify (bit t = task t) |

## Verification
The bench drives retries and clears that name the same task in one cycle. A design that ranked set above clear would leave a task with a stale flag, and its next, unrelated instruction would lose its increment. It drops `multi_mode` while flags are set and retries in single-task mode. A design that ignored the mode would suppress modifies on stalled-pipeline waits, where the modify happens only once. It also checks that events for one task leave the other three bits untouched, and that the output does not change before the edge. A combinational or cross-wired design would inhibit the wrong task or the same-cycle instruction.

// File: rtl/task_retry_pkg.sv
package task_retry_pkg;
  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_action_e;
endpackage

// File: rtl/task_event_decode.sv
module task_event_decode #(
  parameter int NUM_TASKS = 4,
  localparam int TASK_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic              valid,
  input  logic [TASK_W-1:0] sel,
  output logic [NUM_TASKS-1:0] hit
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_TASKS; gi++) begin : g_hit
      assign hit[gi] = valid && (sel == TASK_W'(gi));
    end
  endgenerate
endmodule

// File: rtl/retry_flag_cell.sv
module retry_flag_cell
  import task_retry_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic multi_mode,
  input  logic retry_hit,
  input  logic adv_hit,
  input  logic jump_hit,
  output logic flag
);
  flag_action_e act;

  always_comb begin
    if (!multi_mode || adv_hit || jump_hit) act = FLAG_CLEAR;
    else if (retry_hit)                     act = FLAG_SET;
    else                                    act = FLAG_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else begin
      case (act)
        FLAG_SET:   flag <= 1'b1;
        FLAG_CLEAR: flag <= 1'b0;
        default:    flag <= flag;
      endcase
    end
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !flag);
  p_retry_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (multi_mode && retry_hit && !adv_hit && !jump_hit) |=> flag);
  p_adv_clears_r3: assert property (@(posedge clk) disable iff (rst)
    adv_hit |=> !flag);
  p_jump_clears_r4: assert property (@(posedge clk) disable iff (rst)
    jump_hit |=> !flag);
  p_single_never_r6: assert property (@(posedge clk) disable iff (rst)
    !multi_mode |=> !flag);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (multi_mode && !retry_hit && !adv_hit && !jump_hit) |=> $stable(flag));
endmodule

// File: rtl/task_retry_tracker.sv
module task_retry_tracker #(
  parameter int NUM_TASKS = 4,
  localparam int TASK_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 multi_mode,
  input  logic                 retry_valid,
  input  logic [TASK_W-1:0]    retry_task,
  input  logic                 adv_valid,
  input  logic [TASK_W-1:0]    adv_task,
  input  logic                 jump_valid,
  input  logic [TASK_W-1:0]    jump_task,
  output logic [NUM_TASKS-1:0] suppress
);
  logic [NUM_TASKS-1:0] retry_hit, adv_hit, jump_hit;

  task_event_decode #(.NUM_TASKS(NUM_TASKS)) i_dec_retry (
    .valid(retry_valid), .sel(retry_task), .hit(retry_hit));
  task_event_decode #(.NUM_TASKS(NUM_TASKS)) i_dec_adv (
    .valid(adv_valid), .sel(adv_task), .hit(adv_hit));
  task_event_decode #(.NUM_TASKS(NUM_TASKS)) i_dec_jump (
    .valid(jump_valid), .sel(jump_task), .hit(jump_hit));

  genvar gt;
  generate
    for (gt = 0; gt < NUM_TASKS; gt++) begin : g_task
      retry_flag_cell i_cell (
        .clk(clk), .rst(rst), .multi_mode(multi_mode),
        .retry_hit(retry_hit[gt]), .adv_hit(adv_hit[gt]),
        .jump_hit(jump_hit[gt]), .flag(suppress[gt]));
    end
  endgenerate

  // R5: same-task clear beats retry
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (retry_valid && adv_valid && retry_task == adv_task) |=> !suppress[$past(retry_task)]);
  // R2 at top level: a multitask retry with no clears lands as a set bit
  p_top_set_r2: assert property (@(posedge clk) disable iff (rst)
    (multi_mode && retry_valid && !adv_valid && !jump_valid) |=> suppress[$past(retry_task)]);
endmodule

// File: tb/test_task_retry_tracker.sv
module test_task_retry_tracker;
  logic clk = 0;
  logic rst = 1;
  logic multi_mode = 1;
  logic retry_valid = 0, adv_valid = 0, jump_valid = 0;
  logic [1:0] retry_task = 0, adv_task = 0, jump_task = 0;
  logic [3:0] suppress;
  logic [3:0] model = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  task_retry_tracker i_task_retry_tracker (
    .clk, .rst, .multi_mode, .retry_valid, .retry_task,
    .adv_valid, .adv_task, .jump_valid, .jump_task, .suppress);

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (suppress !== exp) begin
      fails++;
      $display("FAIL %s: suppress=%b expected=%b", req, suppress, exp);
    end
  endtask

  // Applies inputs at a negedge, checks pre-edge stability, advances one edge.
  task automatic step(input bit r, input bit m, input bit rv, input int rt,
                      input bit av, input int at, input bit jv, input int jt);
    rst = r; multi_mode = m;
    retry_valid = rv; retry_task = 2'(rt);
    adv_valid = av; adv_task = 2'(at);
    jump_valid = jv; jump_task = 2'(jt);
    #2 chk("R8", model);
    @(posedge clk);
    for (int t = 0; t < 4; t++) begin
      if (r || !m) model[t] = 0;
      else if ((av && at == t) || (jv && jt == t)) model[t] = 0;
      else if (rv && rt == t) model[t] = 1;
    end
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step(1, 1, 0, 0, 0, 0, 0, 0); chk("R1", 4'b0000);
    step(1, 1, 1, 2, 0, 0, 0, 0); chk("R1", 4'b0000);
    step(0, 1, 1, 2, 0, 0, 0, 0); chk("R2", 4'b0100);
    step(0, 1, 1, 0, 0, 0, 0, 0); chk("R2", 4'b0101);
    step(0, 1, 0, 0, 0, 0, 0, 0); chk("R7", 4'b0101);
    step(0, 1, 0, 0, 1, 2, 0, 0); chk("R3", 4'b0001);
    step(0, 1, 0, 0, 0, 0, 1, 0); chk("R4", 4'b0000);
    step(0, 1, 1, 3, 1, 3, 0, 0); chk("R5", 4'b0000);
    step(0, 1, 1, 1, 0, 0, 0, 0); chk("R2", 4'b0010);
    step(0, 1, 1, 1, 0, 0, 1, 1); chk("R5", 4'b0000);
    step(0, 1, 1, 1, 0, 0, 0, 0); chk("R2", 4'b0010);
    step(0, 0, 0, 0, 0, 0, 0, 0); chk("R6", 4'b0000);
    step(0, 0, 1, 2, 0, 0, 0, 0); chk("R6", 4'b0000);
    step(0, 1, 1, 1, 0, 0, 0, 0); chk("R2", 4'b0010);
    step(0, 1, 1, 3, 1, 0, 1, 2); chk("R7", 4'b1010);
    step(0, 1, 0, 0, 1, 3, 0, 0); chk("R3", 4'b0010);
    step(1, 1, 0, 0, 0, 0, 0, 0); chk("R1", 4'b0000);
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 200) == 0, ($urandom % 10) != 0,
           ($urandom % 2) == 1, int'($urandom % 4),
           ($urandom % 4) == 0, int'($urandom % 4),
           ($urandom % 6) == 0, int'($urandom % 4));
      chk("R7", model);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule